// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a direct-mapped cache placed between a processor word port and a slower main-memory port. Each entry keeps a valid flag, a tag and a block of several words. A read that finds its block returns the chosen word in the same cycle. A read that does not find it stalls the processor, fetches the whole block in one memory transfer, installs it and then retries the access, which then completes as a hit.

Writes always go through to memory. A write that hits updates the cached word and sends the single word to memory, keeping the processor stalled until memory accepts it. A write that misses first loads the whole block, then merges the word and writes it through. Each address maps to exactly one entry, so a new block simply replaces whatever that entry held.

The processor holds its request, address and write data steady while stalled. The memory port uses a request/acknowledge handshake. The number of entries is a parameter: the default is 4096 entries of four 32-bit words.

Top module: `dmc_top`

## Requirements
- R1: After reset every entry is invalid, so the first access to any address misses. With no processor request, the stall output and the memory request are both low.
- R2: Address bits [1:0] are ignored. Bits [3:2] select the word in the block. Bits [INDEX_W+3:4] select the entry. The bits above the index form the tag.
- R3: A read whose entry is valid and whose stored tag equals the address tag completes in its first cycle. The stall output stays low, no memory request is made, and cpu_rdata carries the addressed word.
- R4: On a read miss the stall output is raised and a memory read is requested with mem_we low and a block-aligned address (bits [3:0] zero). In mem_rdata, bits [32k+31:32k] carry the word at block address + 4k.
- R5: In the cycle memory acknowledges a fill, the block, its tag and its valid flag are installed. The next cycle retries the access as a hit, with no memory request. A read miss therefore takes latency + 3 cycles, where latency is the number of unacknowledged request cycles.
- R6: A write hit updates the cached word and requests a memory write with mem_we high. The address is word-aligned and equal to the processor address with bits [1:0] cleared, and mem_wdata equals cpu_wdata. The stall output stays high until the cycle of the acknowledge and is low in that cycle, so the write takes latency + 2 cycles.
- R7: A write miss first fills the block as in R4 and R5, then behaves as a write hit. It takes 2 × latency + 4 cycles, and a later read of any word in that block returns the merged data.
- R8: Two addresses with the same index and different tags replace each other. After the second one is loaded, the first one misses again.
- R9: A memory request, with its address and direction, is held unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rdata | output | 32 | Word read from the cache |
| cpu_stall | output | 1 | Processor must hold its access |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = single-word write, 0 = block read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Word written to memory |
| mem_ack | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 128 | Block returned by memory |

## Verification
Two things can happen in the same cycle. On a write, the cache word is updated and the write-through starts together. On a write miss, the fill acknowledge installs the block just before the word is merged into it. The bench provokes both with memory that acknowledges at once (zero latency) and with memory that acknowledges late. It issues a write that hits and reads the same word back at once. It then evicts that block through a conflicting address and reads it again, so the value must come back from memory. Each access is judged against a behavioural model of tags and memory: the cycle count until the stall drops, the word returned, and the address and data of every memory write.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int INDEX_W = 12,
  parameter int TAG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  input  logic               wr_en,
  input  logic [TAG_W-1:0]   wr_tag
);
  localparam int ENTRIES = 1 << INDEX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx] <= wr_tag;
    end
  end

  assign rd_valid = valid_q[idx];
  assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int INDEX_W = 12,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4
) (
  input  logic                      clk,
  input  logic [INDEX_W-1:0]        idx,
  output logic [DATA_W*WORDS-1:0]   rd_block,
  input  logic                      fill_en,
  input  logic [DATA_W*WORDS-1:0]   fill_block,
  input  logic                      word_en,
  input  logic [$clog2(WORDS)-1:0]  word_sel,
  input  logic [DATA_W-1:0]         word_data
);
  localparam int ENTRIES = 1 << INDEX_W;

  for (genvar lane = 0; lane < WORDS; lane++) begin : g_lane
    logic [DATA_W-1:0] arr_q [ENTRIES];
    logic              lane_we;
    logic [DATA_W-1:0] lane_d;

    always_comb begin
      lane_we = fill_en || (word_en && (word_sel == lane));
      lane_d  = fill_en ? fill_block[lane*DATA_W +: DATA_W] : word_data;
    end

    always_ff @(posedge clk) begin
      if (lane_we) begin
        arr_q[idx] <= lane_d;
      end
    end

    assign rd_block[lane*DATA_W +: DATA_W] = arr_q[idx];
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_we,
  input  logic       hit,
  input  logic       mem_ack,
  output dmc_state_e state,
  output logic       stall,
  output logic       mem_req,
  output logic       mem_we,
  output logic       fill_en,
  output logic       word_en
);
  dmc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    stall   = 1'b0;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    fill_en = 1'b0;
    word_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (!hit) begin
            stall   = 1'b1;
            state_d = ST_FILL;
          end else if (cpu_we) begin
            stall   = 1'b1;
            word_en = 1'b1;
            state_d = ST_WRITE;
          end
        end
      end
      ST_FILL: begin
        stall   = 1'b1;
        mem_req = 1'b1;
        if (mem_ack) begin
          fill_en = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WRITE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        stall   = !mem_ack;
        if (mem_ack) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/dmc_top.sv
module dmc_top #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int INDEX_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_stall,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [DATA_W*WORDS-1:0] mem_rdata
);
  import dmc_pkg::*;

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int BLK_LO = BYTE_W + OFF_W;
  localparam int IDX_HI = BLK_LO + INDEX_W;
  localparam int TAG_W  = ADDR_W - IDX_HI;
  localparam int BLK_W  = DATA_W * WORDS;

  logic [INDEX_W-1:0] a_idx;
  logic [TAG_W-1:0]   a_tag;
  logic [OFF_W-1:0]   a_word;
  logic               rd_valid;
  logic [TAG_W-1:0]   rd_tag;
  logic [BLK_W-1:0]   rd_block;
  logic               hit;
  logic               fill_en;
  logic               word_en;
  dmc_state_e         state;

  assign a_word = cpu_addr[BLK_LO-1:BYTE_W];
  assign a_idx  = cpu_addr[IDX_HI-1:BLK_LO];
  assign a_tag  = cpu_addr[ADDR_W-1:IDX_HI];

  dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (a_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .wr_en    (fill_en),
    .wr_tag   (a_tag)
  );

  dmc_data_store #(.INDEX_W(INDEX_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_data (
    .clk        (clk),
    .idx        (a_idx),
    .rd_block   (rd_block),
    .fill_en    (fill_en),
    .fill_block (mem_rdata),
    .word_en    (word_en),
    .word_sel   (a_word),
    .word_data  (cpu_wdata)
  );

  assign hit = rd_valid && (rd_tag == a_tag);

  dmc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_req (cpu_req),
    .cpu_we  (cpu_we),
    .hit     (hit),
    .mem_ack (mem_ack),
    .state   (state),
    .stall   (cpu_stall),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .fill_en (fill_en),
    .word_en (word_en)
  );

  assign cpu_rdata = rd_block[a_word*DATA_W +: DATA_W];
  assign mem_wdata = cpu_wdata;

  always_comb begin
    if (state == ST_WRITE) begin
      mem_addr = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
    end else begin
      mem_addr = {cpu_addr[ADDR_W-1:BLK_LO], {BLK_LO{1'b0}}};
    end
  end
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 2,
  parameter int BLK_LO = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_fill_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> (mem_addr[BLK_LO-1:0] == '0) && cpu_stall);

  p_retry_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> !mem_req && cpu_req);

  p_wt_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (mem_addr[ADDR_W-1:BYTE_W] == cpu_addr[ADDR_W-1:BYTE_W])
                          && (mem_addr[BYTE_W-1:0] == '0) && (mem_wdata == cpu_wdata));

  p_wt_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (cpu_stall == !mem_ack));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !cpu_stall);
endmodule

bind dmc_top dmc_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BYTE_W (BYTE_W),
  .BLK_LO (BLK_LO)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_stall (cpu_stall),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/dmc_top_test.sv
`timescale 1ns/1ps
module dmc_top_test;
  localparam int IDX_W = 4;
  localparam int SETS  = 1 << IDX_W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cpu_req, cpu_we;
  logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
  logic         cpu_stall;
  logic         mem_req, mem_we, mem_ack;
  logic [31:0]  mem_addr, mem_wdata;
  logic [127:0] mem_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mem_q [logic [29:0]];
  bit          rv   [SETS];
  logic [31:0] rtag [SETS];

  always #4 clk = ~clk;

  dmc_top #(.INDEX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_rd(input logic [29:0] wa);
    if (mem_q.exists(wa)) return mem_q[wa];
    return ({2'b00, wa} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input int lat, input string rq);
    int idx = int'(a[IDX_W+3:4]);
    bit miss = !rv[idx] || (rtag[idx] != (a >> (IDX_W + 4)));
    int exp_cyc;
    int cyc = 0;
    int mcnt = 0;
    bit done = 0;
    if (!we) exp_cyc = miss ? lat + 3 : 1;
    else     exp_cyc = miss ? 2 * lat + 4 : lat + 2;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    while (!done) begin
      mem_ack = 1'b0;
      #1;
      cyc++;
      if (mem_req) begin
        if (mcnt == lat) begin
          mem_ack = 1'b1;
          if (!mem_we) begin
            for (int k = 0; k < 4; k++)
              mem_rdata[32*k +: 32] = mem_rd(mem_addr[31:2] + 30'(k));
            chk(mem_addr == {a[31:4], 4'h0}, rq, "fill address", 64'(mem_addr), 64'({a[31:4], 4'h0}));
          end else begin
            chk(mem_addr == {a[31:2], 2'b00}, rq, "write address", 64'(mem_addr), 64'({a[31:2], 2'b00}));
            chk(mem_wdata == d, rq, "write data", 64'(mem_wdata), 64'(d));
            mem_q[a[31:2]] = d;
          end
        end
        mcnt++;
      end
      #1;
      if (!cpu_stall) done = 1;
      if (cyc > 100) begin
        chk(1'b0, rq, "stall never released", 64'(cyc), 64'(exp_cyc));
        done = 1;
      end
      if (!done || mem_ack) @(posedge clk);
      if (mem_ack) mcnt = 0;
      if (!done) @(negedge clk);
    end
    chk(cyc == exp_cyc, rq, "access cycles", 64'(cyc), 64'(exp_cyc));
    if (!we) chk(cpu_rdata == mem_rd(a[31:2]), rq, "read word", 64'(cpu_rdata), 64'(mem_rd(a[31:2])));
    if (mem_ack == 1'b0) @(posedge clk);
    @(negedge clk);
    mem_ack = 1'b0;
    cpu_req = 1'b0;
    if (miss) begin
      rv[idx] = 1'b1;
      rtag[idx] = a >> (IDX_W + 4);
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < SETS; i++) begin rv[i] = 0; rtag[i] = '0; end
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    mem_ack = 0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!cpu_stall && !mem_req, "R1", "idle after reset", {62'd0, cpu_stall, mem_req}, 0);

    access(0, 32'h0000_1230, 0, 2, "R1");          // cold miss
    access(0, 32'h0000_1238, 0, 2, "R3");          // hit, other word
    access(0, 32'h0000_1237, 0, 2, "R2");          // byte offset ignored
    access(0, 32'h0000_123C, 0, 0, "R4");          // hit, last word
    access(0, 32'h0055_0040, 0, 0, "R5");          // zero-latency fill
    access(0, 32'h0055_0044, 0, 0, "R5");
    access(1, 32'h0000_1234, 32'hCAFE_0001, 0, "R6");
    access(0, 32'h0000_1234, 0, 0, "R6");
    access(1, 32'h0000_1238, 32'hCAFE_0002, 3, "R6");
    access(1, 32'h00AB_C0A8, 32'hBEEF_1111, 2, "R7");  // write miss
    access(0, 32'h00AB_C0A8, 0, 1, "R7");
    access(0, 32'h00AB_C0A0, 0, 1, "R7");
    access(1, 32'h0077_00B0, 32'h1357_9BDF, 0, "R7");
    access(0, 32'h0077_00B0, 0, 0, "R7");
    access(0, 32'h0001_1230, 0, 1, "R8");          // same index as 0x1230
    access(0, 32'h0000_1234, 0, 1, "R8");          // evicted; from memory
    access(0, 32'h0000_1238, 0, 1, "R8");
    access(0, 32'h0001_1234, 0, 4, "R9");          // long latency
    for (int i = 0; i < 8; i++)
      access(i[0], 32'h0100_0000 + 32'(i * 52), 32'h4000_0000 + 32'(i), i % 3, "R3");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule